// File: doc/BRIEF.md
# MDIO Paired-Word Write Slave

This block listens to a two-wire management bus (a clock line and a bidirectional data line) as a slave and turns pairs of 16-bit write frames into single 32-bit writes on a plain internal register-bus port. It runs on the system clock. The management clock and data are brought in through a synchronizer, and each rising edge of the management clock delivers one bit to a frame decoder. The decoder locks onto a preamble of ones and the start pattern. It then collects the opcode, the 5-bit PHY address and the 5-bit register address. For write frames addressed to this slave, it also collects the turnaround bits and the 16 data bits.

A pairing stage keeps one half-word pending. The half is picked by bit 0 of the register address, and the upper register-address bits select a double word. When the opposite half of the same double word arrives in the next frame that concerns the slave, the pairing stage issues one write strobe that carries the combined 32-bit value. The slave never drives the data line.

Frame decoder states, as named in the RTL:
- ST_PREAMBLE counts ones.
- ST_START waits for the second start bit.
- ST_HEADER shifts in the opcode and the two addresses.
- ST_TURN skips the two turnaround bits.
- ST_DATA shifts in the data field.

Decoder transitions:
- PREAMBLE to START, on a 0 after at least 32 ones.
- START to HEADER, on a 1.
- START to PREAMBLE, on a 0.
- HEADER to TURN, on a write frame whose PHY address matches.
- HEADER to PREAMBLE, on any other header.
- TURN to DATA, after 2 bits.
- DATA to PREAMBLE, after 16 bits.

Pairing states: PAIR_EMPTY and PAIR_HALF.

Pairing transitions:
- EMPTY to HALF, when a write completes.
- HALF to HALF, when a write targets another double word. That write replaces the pending half.
- HALF to EMPTY, when the opposite half arrives. The strobe is issued.
- HALF to EMPTY, when the same half arrives again. Both halves are discarded.
- HALF to EMPTY, when a read addressed to the slave completes its header.

Top module: `mdio_pair_slave`

## Requirements
- R1: A frame is accepted only after at least 32 consecutive one bits followed by the start bits 0 then 1. A frame with only 31 ones before the start bits has no effect.
- R2: After the start bits the slave takes, msb first, a 2-bit opcode (01 = write, 10 = read), a 5-bit PHY address and a 5-bit register address. A write then has 2 turnaround bits and 16 data bits, msb first.
- R3: A frame whose PHY address differs from `slave_phy` is ignored and leaves any pending half untouched.
- R4: Register-address bit 0 selects the half: 0 = low, giving `wr_data[15:0]`; 1 = high, giving `wr_data[31:16]`. `wr_addr` is {PHY address, register address bits 4..1}.
- R5: A low half followed by a high half of the same double word produces exactly one strobe. The high half followed by the low half does the same.
- R6: A second write to the same half as the pending one produces no strobe and discards the pending half. A later single half does not pair with the discarded data.
- R7: A write to the opposite half of a different double word produces no strobe. The new write becomes the pending half.
- R8: A read frame addressed to the slave discards the pending half. Frames with opcode 00 or 11 have no effect.
- R9: `mdio_oe` is 0 at all times, so the slave never drives the data line, including during every write frame.
- R10: `wr_en` is high for exactly one clock cycle per committed pair, and no half remains pending after it.
- R11: During and after reset, `wr_en` is 0 and no half is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slave_phy | input | 5 | PHY address this slave answers to |
| mdc | input | 1 | Management clock, asynchronous to clk |
| mdio_i | input | 1 | Management data line as seen at the pin |
| mdio_o | output | 1 | Data line output value (held 0) |
| mdio_oe | output | 1 | Data line output enable (held 0, released) |
| wr_en | output | 1 | One-cycle 32-bit register write strobe |
| wr_addr | output | 9 | Double-word address {PHY, reg[4:1]} |
| wr_data | output | 32 | Combined write data {high half, low half} |

## Verification
Two things can fall on the same system-clock edge. One is the final data bit of a completing half, which commits the pair and empties the pairing stage. The other is the decoder returning to preamble counting for the next frame. A second pair can also start in the cycle just after a strobe. The bench provokes this by sending four write frames back to back with no idle gap: the halves of one double word in low-high order, then the halves of a second double word in high-low order. It judges the result by requiring exactly two strobes, with the address and combined data of each pair in arrival order.

// File: rtl/mdio_pair_pkg.sv
package mdio_pair_pkg;

    typedef enum logic [2:0] {
        ST_PREAMBLE,
        ST_START,
        ST_HEADER,
        ST_TURN,
        ST_DATA
    } frame_state_t;

    typedef enum logic {
        PAIR_EMPTY,
        PAIR_HALF
    } pair_state_t;

    localparam logic [1:0] OPC_WRITE = 2'b01;
    localparam logic [1:0] OPC_READ  = 2'b10;

endpackage

// File: rtl/mdio_edge_sync.sv
module mdio_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mdc,
    input  logic mdio_i,
    output logic mdc_rise,
    output logic mdio_bit
);

    logic [STAGES:0]   mdc_q;
    logic [STAGES-1:0] dat_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mdc_q <= '0;
            dat_q <= '1;
        end else begin
            mdc_q <= {mdc_q[STAGES-1:0], mdc};
            dat_q <= {dat_q[STAGES-2:0], mdio_i};
        end
    end

    assign mdc_rise = mdc_q[STAGES-1] & ~mdc_q[STAGES];
    assign mdio_bit = dat_q[STAGES-1];

endmodule

// File: rtl/mdio_frame_rx.sv
module mdio_frame_rx
    import mdio_pair_pkg::*;
#(
    parameter int PHY_W   = 5,
    parameter int REG_W   = 5,
    parameter int DATA_W  = 16,
    parameter int PRE_LEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_valid,
    input  logic              bit_in,
    input  logic [PHY_W-1:0]  my_phy,
    output logic              wr_done,
    output logic              rd_hit,
    output logic [REG_W-1:0]  f_reg,
    output logic [DATA_W-1:0] f_data
);

    localparam int HDR_LEN = 2 + PHY_W + REG_W;
    localparam int MAX_A   = (PRE_LEN > DATA_W) ? PRE_LEN : DATA_W;
    localparam int MAX_C   = (MAX_A > HDR_LEN) ? MAX_A : HDR_LEN;
    localparam int CNT_W   = $clog2(MAX_C + 1);

    frame_state_t       state, state_nx;
    logic [CNT_W-1:0]   cnt;
    logic [HDR_LEN-2:0] hdr;
    logic [HDR_LEN-1:0] hdr_next;
    logic [1:0]         op_f;
    logic [PHY_W-1:0]   phy_f;
    logic [REG_W-1:0]   reg_f;
    logic               pre_full, last_hdr, last_turn, last_data, phy_hit;

    assign hdr_next  = {hdr, bit_in};
    assign op_f      = hdr_next[HDR_LEN-1 -: 2];
    assign phy_f     = hdr_next[REG_W +: PHY_W];
    assign reg_f     = hdr_next[REG_W-1:0];
    assign phy_hit   = (phy_f == my_phy);
    assign pre_full  = (cnt >= CNT_W'(PRE_LEN));
    assign last_hdr  = (cnt == CNT_W'(HDR_LEN - 1));
    assign last_turn = (cnt == CNT_W'(1));
    assign last_data = (cnt == CNT_W'(DATA_W - 1));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_PREAMBLE;
        else        state <= state_nx;
    end

    // Next-state decode
    always_comb begin
        state_nx = state;
        if (bit_valid) begin
            unique case (state)
                ST_PREAMBLE: if (!bit_in && pre_full) state_nx = ST_START;
                ST_START:    state_nx = bit_in ? ST_HEADER : ST_PREAMBLE;
                ST_HEADER:   if (last_hdr)
                                 state_nx = (op_f == OPC_WRITE && phy_hit) ? ST_TURN : ST_PREAMBLE;
                ST_TURN:     if (last_turn) state_nx = ST_DATA;
                ST_DATA:     if (last_data) state_nx = ST_PREAMBLE;
            endcase
        end
    end

    // Datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            hdr     <= '0;
            f_reg   <= '0;
            f_data  <= '0;
            wr_done <= 1'b0;
            rd_hit  <= 1'b0;
        end else begin
            wr_done <= 1'b0;
            rd_hit  <= 1'b0;
            if (bit_valid) begin
                unique case (state)
                    ST_PREAMBLE: begin
                        if (!bit_in)       cnt <= '0;
                        else if (!pre_full) cnt <= cnt + 1'b1;
                    end
                    ST_START: cnt <= '0;
                    ST_HEADER: begin
                        hdr <= hdr_next[HDR_LEN-2:0];
                        if (last_hdr) begin
                            cnt   <= '0;
                            f_reg <= reg_f;
                            if (op_f == OPC_READ && phy_hit) rd_hit <= 1'b1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_TURN: cnt <= last_turn ? '0 : cnt + 1'b1;
                    ST_DATA: begin
                        f_data <= {f_data[DATA_W-2:0], bit_in};
                        if (last_data) begin
                            cnt     <= '0;
                            wr_done <= 1'b1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/mdio_word_pair.sv
module mdio_word_pair
    import mdio_pair_pkg::*;
#(
    parameter int PHY_W  = 5,
    parameter int REG_W  = 5,
    parameter int DATA_W = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_done,
    input  logic                      rd_hit,
    input  logic [PHY_W-1:0]          my_phy,
    input  logic [REG_W-1:0]          f_reg,
    input  logic [DATA_W-1:0]         f_data,
    output logic                      wr_en,
    output logic [PHY_W+REG_W-2:0]    wr_addr,
    output logic [2*DATA_W-1:0]       wr_data,
    output logic                      pend_valid
);

    localparam int DWA_W = REG_W - 1;

    pair_state_t        pstate, pstate_nx;
    logic               pend_half;
    logic [DWA_W-1:0]   pend_dwa;
    logic [DATA_W-1:0]  pend_data;
    logic               half;
    logic [DWA_W-1:0]   dwa;
    logic               same_dw, match_pair;

    assign half       = f_reg[0];
    assign dwa        = f_reg[REG_W-1:1];
    assign same_dw    = (pend_dwa == dwa);
    assign match_pair = same_dw && (pend_half != half);
    assign pend_valid = (pstate == PAIR_HALF);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pstate <= PAIR_EMPTY;
        else        pstate <= pstate_nx;
    end

    // Next-state decode
    always_comb begin
        pstate_nx = pstate;
        unique case (pstate)
            PAIR_EMPTY: if (wr_done) pstate_nx = PAIR_HALF;
            PAIR_HALF: begin
                if (rd_hit)                        pstate_nx = PAIR_EMPTY;
                else if (wr_done && !same_dw)      pstate_nx = PAIR_HALF;
                else if (wr_done)                  pstate_nx = PAIR_EMPTY;
            end
        endcase
    end

    // Pending half and write port
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_half <= 1'b0;
            pend_dwa  <= '0;
            pend_data <= '0;
            wr_en     <= 1'b0;
            wr_addr   <= '0;
            wr_data   <= '0;
        end else begin
            wr_en <= 1'b0;
            if (wr_done && (pstate == PAIR_EMPTY || !same_dw)) begin
                pend_half <= half;
                pend_dwa  <= dwa;
                pend_data <= f_data;
            end else if (wr_done && pstate == PAIR_HALF && !rd_hit && match_pair) begin
                wr_en   <= 1'b1;
                wr_addr <= {my_phy, dwa};
                wr_data <= half ? {f_data, pend_data} : {pend_data, f_data};
            end
        end
    end

endmodule

// File: rtl/mdio_pair_slave.sv
module mdio_pair_slave #(
    parameter int PHY_W     = 5,
    parameter int REG_W     = 5,
    parameter int DATA_W    = 16,
    parameter int PRE_LEN   = 32,
    parameter int SYNC_STG  = 2,
    localparam int ADDR_W   = PHY_W + REG_W - 1,
    localparam int WORD_W   = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PHY_W-1:0]  slave_phy,
    input  logic              mdc,
    input  logic              mdio_i,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [WORD_W-1:0] wr_data
);

    logic              mdc_rise;
    logic              mdio_bit;
    logic              wr_done;
    logic              rd_hit;
    logic              pend_valid;
    logic [REG_W-1:0]  f_reg;
    logic [DATA_W-1:0] f_data;

    assign mdio_o  = 1'b0;
    assign mdio_oe = 1'b0;

    mdio_edge_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .mdc      (mdc),
        .mdio_i   (mdio_i),
        .mdc_rise (mdc_rise),
        .mdio_bit (mdio_bit)
    );

    mdio_frame_rx #(
        .PHY_W   (PHY_W),
        .REG_W   (REG_W),
        .DATA_W  (DATA_W),
        .PRE_LEN (PRE_LEN)
    ) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_valid (mdc_rise),
        .bit_in    (mdio_bit),
        .my_phy    (slave_phy),
        .wr_done   (wr_done),
        .rd_hit    (rd_hit),
        .f_reg     (f_reg),
        .f_data    (f_data)
    );

    mdio_word_pair #(
        .PHY_W  (PHY_W),
        .REG_W  (REG_W),
        .DATA_W (DATA_W)
    ) u_pair (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_done    (wr_done),
        .rd_hit     (rd_hit),
        .my_phy     (slave_phy),
        .f_reg      (f_reg),
        .f_data     (f_data),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .pend_valid (pend_valid)
    );

endmodule

// File: rtl/mdio_pair_slave_chk.sv
module mdio_pair_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic mdc_rise,
    input logic wr_done,
    input logic rd_hit,
    input logic pend_valid,
    input logic wr_en
);

    AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);  // R10

    AST_EMPTY_AT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !pend_valid);  // R10

    AST_STROBE_AFTER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(wr_done));  // R5

    AST_DONE_ON_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_done |-> $past(mdc_rise));  // R2

    AST_PEND_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_done && !rd_hit) |=> $stable(pend_valid));  // R3

    AST_READ_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hit |=> !pend_valid);  // R8

endmodule

bind mdio_pair_slave mdio_pair_slave_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mdc_rise   (mdc_rise),
    .wr_done    (wr_done),
    .rd_hit     (rd_hit),
    .pend_valid (pend_valid),
    .wr_en      (wr_en)
);

// File: tb/mdio_pair_slave_bench.sv
module mdio_pair_slave_bench;

    localparam logic [4:0] MY_PHY = 5'd9;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mdc = 1'b0;
    logic        mdio_i = 1'b1;
    logic        mdio_o;
    logic        mdio_oe;
    logic        wr_en;
    logic [8:0]  wr_addr;
    logic [31:0] wr_data;

    int          checks = 0;
    int          fails = 0;
    int          strobes = 0;
    logic [8:0]  last_addr = '0, prev_addr = '0;
    logic [31:0] last_data = '0, prev_data = '0;
    logic        oe_seen = 1'b0;

    always #4 clk = ~clk;

    mdio_pair_slave u_mdio_pair_slave (
        .clk       (clk),
        .rst_n     (rst_n),
        .slave_phy (MY_PHY),
        .mdc       (mdc),
        .mdio_i    (mdio_i),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data)
    );

    always @(posedge clk) begin
        if (mdio_oe) oe_seen = 1'b1;
        if (rst_n && wr_en) begin
            strobes   = strobes + 1;
            prev_addr = last_addr;
            prev_data = last_data;
            last_addr = wr_addr;
            last_data = wr_data;
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk);
        mdio_i = b;
        mdc = 1'b0;
        repeat (3) @(negedge clk);
        mdc = 1'b1;
        repeat (4) @(negedge clk);
        mdc = 1'b0;
    endtask

    task automatic send_frame(input int npre, input logic [1:0] op, input logic [4:0] phy,
                              input logic [4:0] rg, input logic [15:0] d);
        for (int i = 0; i < npre; i++) send_bit(1'b1);
        send_bit(1'b0);
        send_bit(1'b1);
        for (int i = 1; i >= 0; i--) send_bit(op[i]);
        for (int i = 4; i >= 0; i--) send_bit(phy[i]);
        for (int i = 4; i >= 0; i--) send_bit(rg[i]);
        send_bit(1'b1);
        send_bit(1'b0);
        for (int i = 15; i >= 0; i--) send_bit(d[i]);
    endtask

    task automatic wr(input logic [4:0] rg, input logic [15:0] d);
        send_frame(32, 2'b01, MY_PHY, rg, d);
    endtask

    task automatic idle();
        @(negedge clk);
        mdc = 1'b0;
        mdio_i = 1'b1;
        repeat (16) @(negedge clk);
    endtask

    function automatic logic [15:0] lo_of(input int i);
        return 16'((i * 16'h0101) ^ 16'hA5C2) & 16'hFFFE;
    endfunction

    function automatic logic [15:0] hi_of(input int i);
        return 16'(~lo_of(i) + 16'(i * 7));
    endfunction

    initial begin
        int base;
        repeat (10) @(negedge clk);
        chk("R11 wr_en in reset", 64'(wr_en), 64'd0);
        chk("R9 mdio_oe in reset", 64'(mdio_oe), 64'd0);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        chk("R11 no strobe after reset", 64'(strobes), 64'd0);

        // R4 R5: sweep all double words in both orders
        for (int i = 0; i < 16; i++) begin
            for (int ord = 0; ord < 2; ord++) begin
                base = strobes;
                if (ord == 0) begin
                    wr(5'(2 * i), lo_of(i));
                    wr(5'(2 * i + 1), hi_of(i));
                end else begin
                    wr(5'(2 * i + 1), hi_of(i));
                    wr(5'(2 * i), lo_of(i));
                end
                idle();
                chk("R5 one strobe per pair", 64'(strobes - base), 64'd1);
                chk("R4 address", 64'(last_addr), 64'({MY_PHY, 4'(i)}));
                chk("R4 data halves", 64'(last_data), 64'({hi_of(i), lo_of(i)}));
            end
        end

        // R6: same half twice discards both
        base = strobes;
        wr(5'd6, 16'h1110);
        wr(5'd6, 16'h2220);
        wr(5'd7, 16'h3333);
        idle();
        chk("R6 repeated half gives no strobe", 64'(strobes - base), 64'd0);
        wr(5'd6, 16'h4440);
        idle();
        chk("R6 fresh pair commits once", 64'(strobes - base), 64'd1);
        chk("R6 data excludes discarded half", 64'(last_data), 64'h3333_4440);

        // R3: other PHY address ignored, pending kept
        base = strobes;
        wr(5'd10, 16'h5550);
        send_frame(32, 2'b01, 5'd10, 5'd11, 16'hBAD0);
        idle();
        chk("R3 foreign PHY no strobe", 64'(strobes - base), 64'd0);
        wr(5'd11, 16'h6666);
        idle();
        chk("R3 pending survived", 64'(strobes - base), 64'd1);
        chk("R3 data", 64'(last_data), 64'h6666_5550);

        // R1: short preamble rejected
        base = strobes;
        wr(5'd12, 16'h7770);
        send_frame(31, 2'b01, MY_PHY, 5'd13, 16'hDEA0);
        idle();
        chk("R1 31-one preamble ignored", 64'(strobes - base), 64'd0);
        send_frame(40, 2'b01, MY_PHY, 5'd13, 16'h8888);
        idle();
        chk("R1 long preamble accepted", 64'(strobes - base), 64'd1);
        chk("R1 data", 64'(last_data), 64'h8888_7770);

        // R7: opposite half of another double word restarts
        base = strobes;
        wr(5'd2, 16'h9990);
        wr(5'd5, 16'hAAAA);
        idle();
        chk("R7 other double word no strobe", 64'(strobes - base), 64'd0);
        wr(5'd4, 16'hBBB0);
        idle();
        chk("R7 second write paired", 64'(strobes - base), 64'd1);
        chk("R7 address", 64'(last_addr), 64'({MY_PHY, 4'd2}));
        chk("R7 data", 64'(last_data), 64'hAAAA_BBB0);

        // R8: read clears pending, odd opcodes ignored
        base = strobes;
        wr(5'd14, 16'hCCC0);
        send_frame(32, 2'b10, MY_PHY, 5'd15, 16'hFFFF);
        wr(5'd15, 16'hDDDD);
        idle();
        chk("R8 read discards pending", 64'(strobes - base), 64'd0);
        send_frame(32, 2'b11, MY_PHY, 5'd15, 16'h0120);
        send_frame(32, 2'b00, MY_PHY, 5'd14, 16'h0340);
        idle();
        chk("R8 odd opcodes no strobe", 64'(strobes - base), 64'd0);
        wr(5'd14, 16'hEEE0);
        idle();
        chk("R8 pending kept over odd opcodes", 64'(strobes - base), 64'd1);
        chk("R8 data", 64'(last_data), 64'hDDDD_EEE0);

        // Back-to-back pairs, no idle between frames (R10)
        base = strobes;
        wr(5'd16, 16'h1230);
        wr(5'd17, 16'h4567);
        wr(5'd19, 16'h89AB);
        wr(5'd18, 16'hCDE0);
        idle();
        chk("R10 two strobes back to back", 64'(strobes - base), 64'd2);
        chk("R10 first addr", 64'(prev_addr), 64'({MY_PHY, 4'd8}));
        chk("R10 first data", 64'(prev_data), 64'h4567_1230);
        chk("R10 second addr", 64'(last_addr), 64'({MY_PHY, 4'd9}));
        chk("R10 second data", 64'(last_data), 64'h89AB_CDE0);

        // R9: line never driven
        chk("R9 mdio_oe never high", 64'(oe_seen), 64'd0);
        chk("R2 strobe idle at end", 64'(wr_en), 64'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks = checks + 1;
        fails = fails + 1;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule